// File: doc/BRIEF.md
# Multiplexed Alphanumeric Display Controller

This block keeps one 7-bit character code for each position of a four-digit, common-cathode, 15-segment alphanumeric display and drives that display by time multiplexing. A host processor writes codes over an 8-bit I/O bus. A shared write strobe is combined with one load select per position, so a single bus write can update any subset of the stored characters. The host scrolls text by rewriting the codes; the block itself only shows what is stored.

A refresh scanner lights one position at a time. Each position stays lit for a parameterised dwell time. One blank cycle, with every cathode and every segment off, separates two positions so that no ghost of the previous character appears. The stored code of the lit position addresses a 128-entry character-generator ROM. The segment pattern and the cathode enable are registered together, so the two stay aligned.

Top module: `alnum_disp_ctrl`

## Requirements
- R1: A position's code register loads `host_data[6:0]` only on a rising edge where `host_wr` is high and that position's bit of `pos_load` is high. With `host_wr` low, no register changes, whatever the selects are.
- R2: Bit 7 of `host_data` is ignored. Writing 0xB1 stores the same code as writing 0x31.
- R3: In one write, every position whose select is high loads the bus value. A write with all selects low changes nothing.
- R4: Segment bit order is a=0, b=1, c=2, d=3, e=4, f=5, left middle=6, right middle=7, upper-left diagonal=8, upper vertical=9, upper-right diagonal=10, lower-right diagonal=11, lower vertical=12, lower-left diagonal=13, point=14. The glyphs are: code 0x30 gives 0x003F, 0x31 gives 0x0006, 0x38 gives 0x00FF, 0x41 gives 0x00F7 and 0x48 gives 0x00F6. Codes 0x00, 0x20 (space) and 0x7F give 0x0000.
- R5: At most one bit of `cathode_en` is high in any cycle. Bit i lights position i, which is loaded through `pos_load[i]`.
- R6: Positions are scanned in the order 0, 1, 2, 3, 0, and so on. Each position is lit for DWELL consecutive cycles, followed by exactly one cycle with all cathodes off.
- R7: While `cathode_en[i]` is high, `seg_out` equals the glyph of position i's stored code. In any cycle with no cathode enabled, `seg_out` is zero.
- R8: A synchronous reset clears every code register and drives `cathode_en` and `seg_out` to zero from the first edge at which reset is seen. After release, `cathode_en` becomes 0001 on the third rising edge, and the scan then continues as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host I/O write strobe |
| pos_load | input | 4 | Per-position load selects |
| host_data | input | 8 | Host data bus; only bits 6:0 are used |
| cathode_en | output | 4 | Registered cathode enables, at most one high |
| seg_out | output | 15 | Registered segment pattern of the lit position |

## Verification
A write lands in the code registers on the edge where it is accepted. It can reach the segment pins no sooner than two further edges later: one for the ROM read and one for the output register. The bench therefore lets four cycles pass after each write before it observes, then watches two full scan rounds. In that window it matches each lit position against its expected glyph. After reset release the first cathode is due exactly on the third edge. The bench samples on falling edges and compares every cycle from that point with the computed cycle pattern of dwell and blank phases.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int unsigned CODE_W = 7;
  localparam int unsigned SEG_W  = 15;

  // Character generator: computed glyph for each 7-bit code.
  function automatic logic [SEG_W-1:0] glyph_of(input logic [CODE_W-1:0] c);
    logic [SEG_W-1:0] g;
    case (c)
      7'h2D: g = 15'h00C0;  // minus
      7'h2E: g = 15'h4000;  // point
      7'h30: g = 15'h003F;
      7'h31: g = 15'h0006;
      7'h32: g = 15'h00DB;
      7'h33: g = 15'h00CF;
      7'h34: g = 15'h00E6;
      7'h35: g = 15'h00ED;
      7'h36: g = 15'h00FD;
      7'h37: g = 15'h0007;
      7'h38: g = 15'h00FF;
      7'h39: g = 15'h00EF;
      7'h41: g = 15'h00F7;
      7'h42: g = 15'h128F;
      7'h43: g = 15'h0039;
      7'h44: g = 15'h120F;
      7'h45: g = 15'h0079;
      7'h46: g = 15'h0071;
      7'h47: g = 15'h00BD;
      7'h48: g = 15'h00F6;
      7'h49: g = 15'h1209;
      7'h4A: g = 15'h001E;
      7'h4B: g = 15'h0C70;
      7'h4C: g = 15'h0038;
      7'h4D: g = 15'h0536;
      7'h4E: g = 15'h0936;
      7'h4F: g = 15'h003F;
      7'h50: g = 15'h00F3;
      7'h51: g = 15'h083F;
      7'h52: g = 15'h08F3;
      7'h53: g = 15'h00ED;
      7'h54: g = 15'h1201;
      7'h55: g = 15'h003E;
      7'h56: g = 15'h2430;
      7'h57: g = 15'h2836;
      7'h58: g = 15'h2D00;
      7'h59: g = 15'h1500;
      7'h5A: g = 15'h2409;
      default: g = '0;      // space and codes without a glyph
    endcase
    return g;
  endfunction
endpackage

// File: rtl/adc_code_regs.sv
module adc_code_regs #(
  parameter int unsigned N_POS  = 4,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned CODE_W = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_wr,
  input  logic [N_POS-1:0]        pos_load,
  input  logic [BUS_W-1:0]        host_data,
  output logic [N_POS*CODE_W-1:0] codes
);
  for (genvar i = 0; i < N_POS; i++) begin : g_pos
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= '0;
      end else if (host_wr && pos_load[i]) begin
        code_q <= host_data[CODE_W-1:0];
      end
    end
    assign codes[i*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/adc_char_rom.sv
module adc_char_rom
  import adc_pkg::*;
#(
  parameter int unsigned DEPTH = 1 << CODE_W
) (
  input  logic              clk,
  input  logic [CODE_W-1:0] addr,
  output logic [SEG_W-1:0]  data
);
  logic [SEG_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = glyph_of(CODE_W'(i));
  end

  always_ff @(posedge clk) data <= mem[addr];
endmodule

// File: rtl/adc_scanner.sv
module adc_scanner #(
  parameter int unsigned N_POS = 4,
  parameter int unsigned DWELL = 4,
  localparam int unsigned POS_W = (N_POS > 1) ? $clog2(N_POS) : 1,
  localparam int unsigned CNT_W = $clog2(DWELL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos,
  output logic             lit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      lit   <= 1'b0;
      cnt_q <= '0;
    end else if (!lit) begin
      lit   <= 1'b1;
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(DWELL - 1)) begin
      lit <= 1'b0;
      pos <= (pos == POS_W'(N_POS - 1)) ? '0 : pos + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/alnum_disp_ctrl.sv
module alnum_disp_ctrl
  import adc_pkg::*;
#(
  parameter int unsigned N_POS = 4,
  parameter int unsigned BUS_W = 8,
  parameter int unsigned DWELL = 50000,
  localparam int unsigned POS_W = (N_POS > 1) ? $clog2(N_POS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [N_POS-1:0] pos_load,
  input  logic [BUS_W-1:0] host_data,
  output logic [N_POS-1:0] cathode_en,
  output logic [SEG_W-1:0] seg_out
);
  logic [N_POS*CODE_W-1:0] code_flat;
  logic [POS_W-1:0]        scan_pos, pos_d;
  logic                    scan_lit, lit_d;
  logic [SEG_W-1:0]        rom_q;

  adc_code_regs #(.N_POS(N_POS), .BUS_W(BUS_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .pos_load(pos_load),
    .host_data(host_data), .codes(code_flat)
  );

  adc_scanner #(.N_POS(N_POS), .DWELL(DWELL)) u_scan (
    .clk(clk), .rst(rst), .pos(scan_pos), .lit(scan_lit)
  );

  adc_char_rom u_rom (
    .clk(clk), .addr(code_flat[scan_pos*CODE_W +: CODE_W]), .data(rom_q)
  );

  // Delay the scan state by the ROM read latency, then register both outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      lit_d      <= 1'b0;
      pos_d      <= '0;
      cathode_en <= '0;
      seg_out    <= '0;
    end else begin
      lit_d      <= scan_lit;
      pos_d      <= scan_pos;
      cathode_en <= lit_d ? (N_POS'(1) << pos_d) : '0;
      seg_out    <= lit_d ? rom_q : '0;
    end
  end
endmodule

// File: rtl/adc_checker.sv
module adc_checker #(
  parameter int unsigned N_POS  = 4,
  parameter int unsigned SEG_W  = 15,
  parameter int unsigned CODE_W = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    host_wr,
  input logic [N_POS-1:0]        pos_load,
  input logic [N_POS-1:0]        cathode_en,
  input logic [SEG_W-1:0]        seg_out,
  input logic [N_POS*CODE_W-1:0] code_flat
);
  logic past_rst = 1'b0;
  always_ff @(posedge clk) past_rst <= rst;

  assert_one_cathode_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cathode_en));

  assert_dark_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (cathode_en == '0) |-> (seg_out == '0));

  assert_blank_between_R6: assert property (@(posedge clk) disable iff (rst)
    ((cathode_en != '0) && ($past(cathode_en) != '0)) |-> (cathode_en == $past(cathode_en)));

  assert_no_sel_no_change_R3: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && (pos_load != '0)) |=> $stable(code_flat));

  assert_reset_blanks_R8: assert property (@(posedge clk)
    past_rst |-> ((cathode_en == '0) && (seg_out == '0) && (code_flat == '0)));
endmodule

bind alnum_disp_ctrl adc_checker #(.N_POS(N_POS), .SEG_W(adc_pkg::SEG_W), .CODE_W(adc_pkg::CODE_W)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .pos_load(pos_load),
  .cathode_en(cathode_en), .seg_out(seg_out), .code_flat(code_flat)
);

// File: tb/alnum_disp_ctrl_tb.sv
module alnum_disp_ctrl_tb;
  localparam int NP = 4;
  localparam int DW = 4;
  localparam int PER = DW + 1;

  typedef struct packed {
    logic        wr;
    logic [3:0]  sel;
    logic [7:0]  data;
    logic [14:0] e3, e2, e1, e0;
  } vec_t;

  // Expected glyphs follow R4; each row: write, then expected segs per position.
  localparam vec_t VECS [9] = '{
    '{1'b1, 4'b0001, 8'h30, 15'h0000, 15'h0000, 15'h0000, 15'h003F}, // R1
    '{1'b1, 4'b0010, 8'hB1, 15'h0000, 15'h0000, 15'h0006, 15'h003F}, // R2
    '{1'b1, 4'b1100, 8'h41, 15'h00F7, 15'h00F7, 15'h0006, 15'h003F}, // R3
    '{1'b0, 4'b1111, 8'h38, 15'h00F7, 15'h00F7, 15'h0006, 15'h003F}, // R1
    '{1'b1, 4'b0000, 8'h38, 15'h00F7, 15'h00F7, 15'h0006, 15'h003F}, // R3
    '{1'b1, 4'b0100, 8'h48, 15'h00F7, 15'h00F6, 15'h0006, 15'h003F}, // R4
    '{1'b1, 4'b1000, 8'h20, 15'h0000, 15'h00F6, 15'h0006, 15'h003F}, // R4
    '{1'b1, 4'b0001, 8'h7F, 15'h0000, 15'h00F6, 15'h0006, 15'h0000}, // R4
    '{1'b1, 4'b0010, 8'h38, 15'h0000, 15'h00F6, 15'h00FF, 15'h0000}  // R7
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic [3:0] pos_load = '0;
  logic [7:0] host_data = '0;
  logic [3:0] cathode_en;
  logic [14:0] seg_out;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  alnum_disp_ctrl #(.N_POS(NP), .BUS_W(8), .DWELL(DW)) u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .pos_load(pos_load),
    .host_data(host_data), .cathode_en(cathode_en), .seg_out(seg_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Watch two scan rounds; compare each lit position with its expected glyph.
  task automatic observe(input logic [14:0] e [4], input string req);
    int seen [4];
    int miss [4];
    int dark_bad;
    logic [14:0] got [4];
    dark_bad = 0;
    for (int p = 0; p < 4; p++) begin seen[p] = 0; miss[p] = 0; got[p] = '0; end
    for (int k = 0; k < 2 * NP * PER; k++) begin
      @(negedge clk);
      if (cathode_en == 4'b0000) begin
        if (seg_out != '0) dark_bad++;
      end else begin
        for (int p = 0; p < 4; p++) begin
          if (cathode_en == 4'(1 << p)) begin
            seen[p]++;
            if (seg_out != e[p]) begin miss[p]++; got[p] = seg_out; end
          end
        end
      end
    end
    for (int p = 0; p < 4; p++) begin
      check({req, " lit count"}, seen[p], 2 * DW);
      check({req, " glyph"}, (miss[p] == 0) ? {17'd0, e[p]} : {17'd0, got[p]}, {17'd0, e[p]});
    end
    check("R7 dark segments", dark_bad, 0);
  endtask

  initial begin
    logic [14:0] ex [4];
    int mism;
    step(3);
    check("R8 cathode in reset", cathode_en, 0);
    check("R8 seg in reset", seg_out, 0);
    rst = 1'b0;
    step(1);
    check("R8 dark after release 1", cathode_en, 0);
    step(1);
    check("R8 dark after release 2", cathode_en, 0);
    step(1);
    check("R8 first enable", cathode_en, 4'b0001);
    // R6: cycle k from first lit cycle follows dwell/blank pattern; R5 one-hot.
    mism = 0;
    for (int k = 0; k < 3 * NP * PER; k++) begin
      logic [3:0] want;
      want = ((k % PER) < DW) ? 4'(1 << ((k / PER) % NP)) : 4'b0000;
      if (cathode_en !== want) mism++;
      if (k < 3 * NP * PER - 1) @(negedge clk);
    end
    check("R6 scan order and dwell", mism, 0);

    for (int v = 0; v < 9; v++) begin
      host_wr = VECS[v].wr;
      pos_load = VECS[v].sel;
      host_data = VECS[v].data;
      step(1);
      host_wr = 1'b0;
      pos_load = '0;
      host_data = '0;
      step(4);
      ex[0] = VECS[v].e0; ex[1] = VECS[v].e1; ex[2] = VECS[v].e2; ex[3] = VECS[v].e3;
      observe(ex, $sformatf("R1-vector%0d", v));
    end

    // R8: reset mid-run blanks at once and clears every code.
    rst = 1'b1;
    step(1);
    check("R8 cathode after mid reset", cathode_en, 0);
    check("R8 seg after mid reset", seg_out, 0);
    step(1);
    rst = 1'b0;
    step(3);
    check("R8 restart at position 0", cathode_en, 4'b0001);
    ex[0] = '0; ex[1] = '0; ex[2] = '0; ex[3] = '0;
    observe(ex, "R8 cleared codes");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule